// File: doc/BRIEF.md
# Pixel Stream Egress with Line-End Flush

This block sits on the read side of a clock-crossing pixel FIFO and drives a stream master port carrying pixel data, a valid/ready handshake, an end-of-line marker (`m_tlast`) and a start-of-frame marker (`m_tuser`). It decides on every cycle whether to pop the FIFO. The popped pixel first goes into a one-entry hold register and then into the output register. `m_tvalid` stays high for as long as the output register holds a real pixel.

The hold register adds a stage, so the last pixel of a line would stay stuck there until the next line began to arrive. To avoid that, the block reads the FIFO once more while it is empty. This extra read only happens when the held pixel is an end-of-line pixel. It moves that pixel into the output register during horizontal blanking. The entry returned by the empty read is marked invalid. It travels through the pipeline like any other entry but is never shown with `m_tvalid` high.

A clock enable freezes the whole block. Two synchronous resets both return the block to idle: `rst` for the whole core and `aresetn` for the stream side.

Top module: `vid_stream_flush`

## Requirements
- R1: While `rst` is high, `m_tvalid` and `fifo_rd` are low, even when the FIFO holds data.
- R2: Pixels reach the stream in FIFO order, each exactly once. `fifo_rd` pulses in any enabled cycle where the FIFO is non-empty and the output register is free, meaning `m_tvalid` is low or `m_tready` is high.
- R3: `m_tvalid` is high exactly when the output register holds a pixel that was read from a non-empty FIFO. After a handshake with no pixel to replace it, `m_tvalid` drops.
- R4: While `m_tvalid` is high and `m_tready` is low, `fifo_rd` stays low and `m_tdata`, `m_tlast` and `m_tuser` hold their values.
- R5: Suppose the held pixel has its end-of-line flag set, the FIFO is empty and the output register is free. Then `fifo_rd` is issued against the empty FIFO, and in the next cycle the end-of-line pixel is on the stream with `m_tvalid` and `m_tlast` high.
- R6: An entry read from an empty FIFO never produces a beat. Across a run, the number of stream beats equals the number of pixels written into the FIFO.
- R7: Suppose the held pixel has its end-of-line flag clear and the FIFO is empty. Then no read is issued and that pixel stays held. Once a flush has been done, no further empty reads follow.
- R8: While `aclken` is low, `fifo_rd` is low, the outputs hold their values and `m_tready` has no effect.
- R9: `aresetn` low clears the stream state, so `m_tvalid` is low on the next cycle. Streaming resumes normally afterwards.
- R10: `m_tuser` carries the start-of-frame flag of the pixel being presented, in step with its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Stream clock |
| aclken | input | 1 | Clock enable; low freezes the block |
| aresetn | input | 1 | Stream-side synchronous reset, active low |
| rst | input | 1 | Core synchronous reset, active high |
| fifo_empty | input | 1 | FIFO has no entry at its head |
| fifo_data | input | DATA_W | Pixel at the FIFO head |
| fifo_eol | input | 1 | End-of-line flag of the head pixel |
| fifo_sof | input | 1 | Start-of-frame flag of the head pixel |
| fifo_rd | output | 1 | Pop strobe; may be issued when empty during a flush |
| m_tdata | output | DATA_W | Stream pixel data |
| m_tvalid | output | 1 | Stream valid |
| m_tready | input | 1 | Stream ready from the consumer |
| m_tlast | output | 1 | End-of-line marker |
| m_tuser | output | 1 | Start-of-frame marker |

## Verification
The assertions watch several properties on every cycle. No read is issued under backpressure or while the clock enable is low. The outputs hold while a beat is stalled or the block is frozen. An empty read always puts an end-of-line beat on the stream in the next cycle, and it is never followed directly by a second empty read. The bench's reference model checks the rest. It confirms that pixels come out in order with their sideband flags, and that a partial line parks its last pixel with no stray reads. It also shows that the end-of-line pixel arrives during blanking with no new input, and that the beat count matches the pixel count under random stalls and clock-enable gaps.

// File: rtl/vid_stream_flush.sv
module vid_stream_flush #(
  parameter int DATA_W = 8
) (
  input  logic              aclk,
  input  logic              aclken,
  input  logic              aresetn,
  input  logic              rst,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_eol,
  input  logic              fifo_sof,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              m_tuser
);

  logic              clr;
  logic              out_free;
  logic              flush_due;
  logic              h_vld;
  logic [DATA_W-1:0] h_data;
  logic              h_eol;
  logic              h_sof;

  assign clr       = rst | ~aresetn;
  assign out_free  = ~m_tvalid | m_tready;
  assign flush_due = h_vld & h_eol;
  assign fifo_rd   = ~clr & aclken & out_free & (~fifo_empty | flush_due);

  always_ff @(posedge aclk) begin
    if (clr) begin
      h_vld    <= 1'b0;
      h_data   <= '0;
      h_eol    <= 1'b0;
      h_sof    <= 1'b0;
      m_tvalid <= 1'b0;
      m_tdata  <= '0;
      m_tlast  <= 1'b0;
      m_tuser  <= 1'b0;
    end else if (aclken) begin
      if (fifo_rd) begin
        m_tvalid <= h_vld;
        m_tdata  <= h_data;
        m_tlast  <= h_eol;
        m_tuser  <= h_sof;
        h_vld    <= ~fifo_empty;
        h_data   <= fifo_data;
        h_eol    <= fifo_eol;
        h_sof    <= fifo_sof;
      end else if (m_tready) begin
        m_tvalid <= 1'b0;
      end
    end
  end

  AST_BP_NO_READ: assert property (@(posedge aclk) disable iff (clr)
    m_tvalid && !m_tready |-> !fifo_rd); // R4
  AST_BP_HOLD: assert property (@(posedge aclk) disable iff (clr)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)); // R4
  AST_FLUSH_DELIVERS: assert property (@(posedge aclk) disable iff (clr)
    fifo_rd && fifo_empty |=> m_tvalid && m_tlast); // R5
  AST_NO_REPEAT_OVERREAD: assert property (@(posedge aclk) disable iff (clr)
    fifo_rd && fifo_empty |=> !(fifo_rd && fifo_empty)); // R7
  AST_CE_NO_READ: assert property (@(posedge aclk) disable iff (clr)
    !aclken |-> !fifo_rd); // R8
  AST_CE_FREEZE: assert property (@(posedge aclk) disable iff (clr)
    !aclken |=> $stable(m_tvalid) && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)); // R8

endmodule

// File: tb/vid_stream_flush_tb.sv
module vid_stream_flush_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         aclken, aresetn, rst;
  logic         fifo_empty, fifo_eol, fifo_sof, fifo_rd;
  logic [W-1:0] fifo_data, m_tdata;
  logic         m_tvalid, m_tready, m_tlast, m_tuser;

  vid_stream_flush #(.DATA_W(W)) u_dut (
    .aclk(clk), .aclken(aclken), .aresetn(aresetn), .rst(rst),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_eol(fifo_eol), .fifo_sof(fifo_sof),
    .fifo_rd(fifo_rd), .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .m_tuser(m_tuser));

  int total = 0, bad = 0, done = 0;
  int beats = 0, eol_beats = 0, sof_beats = 0, pushed = 0, rd_cnt = 0;
  logic [W+1:0] fq[$];
  logic [W+1:0] hold_e, out_e;
  logic hold_v = 1'b0, out_v = 1'b0;
  logic [7:0] dcnt = 8'd0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sync_fifo();
    fifo_empty = (fq.size() == 0);
    if (fq.size() > 0) {fifo_sof, fifo_eol, fifo_data} = fq[0];
    else {fifo_sof, fifo_eol, fifo_data} = '0;
  endtask

  function automatic logic [W+1:0] px(input logic sof, input logic eol);
    px = {sof, eol, dcnt};
  endfunction

  task automatic step(input logic push, input logic sof, input logic eol, input logic rdy, input logic ce);
    logic clr_now, exp_rd, pop;
    logic n_hv, n_ov;
    logic [W+1:0] n_he, n_oe;
    string rq;
    @(negedge clk);
    if (push) begin fq.push_back(px(sof, eol)); dcnt = dcnt + 8'd1; pushed++; end
    sync_fifo();
    m_tready = rdy;
    aclken = ce;
    #1;
    clr_now = rst | ~aresetn;
    exp_rd = !clr_now && ce && (!out_v || rdy) && (fq.size() > 0 || (hold_v && hold_e[W]));
    rq = !ce ? "R8 rd" : (out_v && !rdy) ? "R4 rd" : (fq.size() == 0) ? "R5/R7 rd" : "R2 rd";
    check(rq, fifo_rd, exp_rd);
    check("R3 tvalid", m_tvalid, out_v);
    if (out_v) begin
      check(!ce ? "R8 tdata" : "R2 tdata", m_tdata, out_e[W-1:0]);
      check("R5 tlast", m_tlast, out_e[W]);
      check("R10 tuser", m_tuser, out_e[W+1]);
    end
    if (fifo_rd) rd_cnt++;
    if (!clr_now && ce && out_v && rdy) begin
      beats++;
      if (out_e[W]) eol_beats++;
      if (out_e[W+1]) sof_beats++;
    end
    pop = 1'b0; n_hv = hold_v; n_he = hold_e; n_ov = out_v; n_oe = out_e;
    if (clr_now) begin
      n_hv = 1'b0; n_ov = 1'b0;
    end else if (ce) begin
      if (exp_rd) begin
        n_ov = hold_v; n_oe = hold_e;
        n_hv = (fq.size() > 0);
        if (n_hv) begin n_he = fq[0]; pop = 1'b1; end
      end else if (rdy) n_ov = 1'b0;
    end
    @(posedge clk);
    #1;
    if (pop) void'(fq.pop_front());
    sync_fifo();
    hold_v = n_hv; hold_e = n_he; out_v = n_ov; out_e = n_oe;
  endtask

  task automatic idle(input int n, input int rdy_mode, input int ce_mode);
    for (int i = 0; i < n; i++)
      step(1'b0, 1'b0, 1'b0,
           rdy_mode == 1 ? 1'b1 : 1'($urandom % 2),
           ce_mode == 1 ? 1'b1 : 1'(($urandom % 4) != 0));
  endtask

  task automatic line(input int n, input logic sof, input int rdy_mode, input int ce_mode);
    for (int i = 0; i < n; i++)
      step(1'b1, sof && i == 0, i == n - 1,
           rdy_mode == 1 ? 1'b1 : 1'($urandom % 2),
           ce_mode == 1 ? 1'b1 : 1'(($urandom % 4) != 0));
  endtask

  initial begin
    int b0, r0;
    rst = 1'b1; aresetn = 1'b1; aclken = 1'b1; m_tready = 1'b0;
    sync_fifo();
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    #0;
    check("R1 tvalid in reset", m_tvalid, 1'b0);
    check("R1 rd in reset", fifo_rd, 1'b0);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, i == 3, 1'b1, 1'b1);
    idle(6, 1, 1);
    check("R5 eol flushed in blanking", eol_beats, 1);
    check("R2 line beats", beats, 6);
    check("R10 sof beats", sof_beats, 1);

    b0 = beats;
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    idle(4, 1, 1);
    r0 = rd_cnt;
    idle(6, 1, 1);
    check("R7 no reads with non-eol held", rd_cnt - r0, 0);
    check("R7 partial line parked", beats - b0, 2);
    step(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    idle(6, 1, 1);
    check("R5 line completed", beats - b0, 4);
    check("R5 eol count", eol_beats, 2);

    line(10, 1'b1, 0, 1);
    idle(30, 0, 1);
    line(7, 1'b0, 0, 0);
    line(5, 1'b1, 0, 0);
    idle(40, 0, 0);

    line(3, 1'b0, 1, 1);
    r0 = rd_cnt;
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'($urandom % 2), 1'b0);
    check("R8 no reads while disabled", rd_cnt - r0, 0);
    idle(10, 1, 1);
    check("R6 beats equal pixels", beats, pushed);

    line(4, 1'b1, 0, 1);
    aresetn = 1'b0;
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    fq.delete();
    sync_fifo();
    #0;
    check("R9 tvalid cleared", m_tvalid, 1'b0);
    aresetn = 1'b1;
    b0 = beats;
    line(6, 1'b1, 0, 1);
    idle(20, 1, 1);
    check("R9 resumed line", beats - b0, 6);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (done == 0) begin
      bad++; total++;
      $display("FAIL R2 watchdog act=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule